// File: doc/BRIEF.md
# Frame Phase Status Measurer

This block measures where a received-frame marker falls inside the local 32-channel serial-bus frame. The local bus runs at 2.048 MHz, so each frame has 256 bit slots: 32 channels of 8 bits each. The block counts local bit slots from the local frame pulse. On each rising edge of the 8 kHz marker it captures the current slot. The marker's rising edge is tied to bit 2 of channel 17 of the received T1 frame. The captured value forms an 8-bit phase word: the upper five bits give the local channel and the lower three give the bit inside that channel. A ninth bit, the frame-count bit, sits above the phase word as its most significant bit.

If the received line is faster than the local clock, successive phase words fall. If it is slower, they rise. When a reading crosses the frame boundary in either direction, the frame-count bit toggles. This lets a host that averages the readings follow the drift for longer than one frame. Whether a reading crossed the boundary is decided from the step between it and the previous reading. Any step of more than half a frame (128 slots) is taken to be a crossing.

A small state machine sequences the block. `ST_ALIGN` is entered at reset and ignores markers. It moves to `ST_FIRST` on the first local frame pulse. `ST_FIRST` takes one capture without any crossing test and then moves to `ST_TRACK`. `ST_TRACK` stays put and tests every later capture for a crossing. The block leaves `ST_TRACK` only through reset.

Top module: `phase_status_meter`

## Requirements
- R1: While reset is asserted, and on its release, `phase_o` is 0, `frame_cnt_o` is 0 and `valid_o` is 0.
- R2: The local slot is 0 in the clock cycle in which `frame_pulse_i` is high. It rises by one in each later cycle and wraps from 255 to 0 without another pulse. A marker edge in the same cycle as the pulse therefore captures 0.
- R3: A marker rising edge is the first cycle in which `marker_i` is sampled high after being sampled low. In the cycle after such an edge, `valid_o` is high for exactly one cycle. In that same cycle, `phase_o[7:3]` holds the local channel and `phase_o[2:0]` holds the bit of the slot seen at the edge.
- R4: In `ST_ALIGN`, before the first frame pulse after reset, marker edges produce no `valid_o` and leave `phase_o` at 0.
- R5: The first capture after alignment, taken in `ST_FIRST`, never toggles `frame_cnt_o`.
- R6: In `ST_TRACK`, a capture below the previous one by more than 128 slots counts as an upward crossing and toggles `frame_cnt_o`.
- R7: In `ST_TRACK`, a capture above the previous one by more than 128 slots counts as a downward crossing and toggles `frame_cnt_o`.
- R8: A step of 128 slots or less in either direction, including exactly 128, leaves `frame_cnt_o` unchanged.
- R9: Between captures, `phase_o` and `frame_cnt_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bit clock, one cycle per bus bit slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse_i | input | 1 | Local frame pulse; marks slot 0 |
| marker_i | input | 1 | Received-frame marker; rising edge triggers a capture |
| phase_o | output | 8 | Captured phase word: channel in [7:3], bit in [2:0] |
| frame_cnt_o | output | 1 | Frame-count bit, the ninth phase bit |
| valid_o | output | 1 | One-cycle strobe when a new phase word is available |

## Verification
Each result is due one clock after the marker is first sampled high. The slot number, the `valid_o` strobe and the frame-count toggle all appear together in that cycle, and `valid_o` falls again one clock later. The bench tracks in its own model which slot the design will see at each rising edge. It drives inputs on the falling edge and reads outputs one nanosecond after the rising edge that registers them. Each capture is followed by one more clock in which the strobe must be low and the word must be unchanged.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_FIRST = 2'd1,
        ST_TRACK = 2'd2
    } meter_state_e;

endpackage

// File: rtl/slot_counter.sv
// Local bit-slot position: zero in the frame-pulse cycle, +1 per clock after.
module slot_counter #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse_i,
    output logic [POS_W-1:0] cur_o
);
    logic [POS_W-1:0] pos_q;

    always_comb begin
        cur_o = frame_pulse_i ? '0 : pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= cur_o + POS_W'(1);
        end
    end
endmodule

// File: rtl/marker_edge.sv
// Rising-edge detector on the received-frame marker.
module marker_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic marker_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= marker_i;
        end
    end

    always_comb begin
        rise_o = marker_i && !prev_q;
    end
endmodule

// File: rtl/wrap_judge.sv
// Decides whether the step from prev to cur crossed the frame boundary.
module wrap_judge #(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0] prev_i,
    input  logic [POS_W-1:0] cur_i,
    output logic             wrap_o
);
    localparam logic [POS_W-1:0] HALF = POS_W'(1) << (POS_W - 1);

    logic [POS_W-1:0] rise_dist;
    logic [POS_W-1:0] fall_dist;

    always_comb begin
        rise_dist = cur_i - prev_i;
        fall_dist = prev_i - cur_i;
        if (cur_i > prev_i) begin
            wrap_o = rise_dist > HALF;
        end else begin
            wrap_o = fall_dist > HALF;
        end
    end
endmodule

// File: rtl/phase_status_meter.sv
module phase_status_meter
    import phase_meter_pkg::*;
#(
    parameter  int CH_W  = 5,
    parameter  int BIT_W = 3,
    localparam int POS_W = CH_W + BIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse_i,
    input  logic             marker_i,
    output logic [POS_W-1:0] phase_o,
    output logic             frame_cnt_o,
    output logic             valid_o
);
    meter_state_e     state_q;
    meter_state_e     state_d;
    logic [POS_W-1:0] cur_slot;
    logic             rise;
    logic             wrap;
    logic             take;

    slot_counter #(.POS_W(POS_W)) u_slot (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .cur_o         (cur_slot)
    );

    marker_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .marker_i (marker_i),
        .rise_o   (rise)
    );

    wrap_judge #(.POS_W(POS_W)) u_wrap (
        .prev_i (phase_o),
        .cur_i  (cur_slot),
        .wrap_o (wrap)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ALIGN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALIGN: if (frame_pulse_i) state_d = ST_FIRST;
            ST_FIRST: if (rise)          state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_ALIGN;
        endcase
    end

    always_comb begin
        take = rise && (state_q != ST_ALIGN);
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_o     <= '0;
            frame_cnt_o <= 1'b0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= take;
            if (take) begin
                phase_o <= cur_slot;
                if (state_q == ST_TRACK && wrap) begin
                    frame_cnt_o <= !frame_cnt_o;
                end
            end
        end
    end
endmodule

// File: rtl/phase_meter_checker.sv
module phase_meter_checker #(
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse_i,
    input logic             marker_i,
    input logic [POS_W-1:0] phase_o,
    input logic             frame_cnt_o,
    input logic             valid_o
);
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r3_valid_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(marker_i));

    a_r9_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(phase_o));

    a_r9_fcnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(frame_cnt_o));

    a_r2_pulse_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(frame_pulse_i)) |-> (phase_o == '0));
endmodule

bind phase_status_meter phase_meter_checker #(.POS_W(POS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .marker_i      (marker_i),
    .phase_o       (phase_o),
    .frame_cnt_o   (frame_cnt_o),
    .valid_o       (valid_o)
);

// File: tb/phase_status_meter_test.sv
module phase_status_meter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp = 1'b0;
    logic       mk = 1'b0;
    logic [7:0] phase;
    logic       fcnt;
    logic       valid;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] nextpos = 8'd0;
    logic [7:0] last_cap = 8'd0;
    logic       exp_fc = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    phase_status_meter uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (fp),
        .marker_i      (mk),
        .phase_o       (phase),
        .frame_cnt_o   (fcnt),
        .valid_o       (valid)
    );

    // {target slot, expected toggle}
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        {8'd10,  1'b0},  // R5 first capture, no toggle
        {8'd20,  1'b0},  // R8 small rise
        {8'd200, 1'b1},  // R7 rise by 180 -> downward crossing
        {8'd5,   1'b1},  // R6 fall by 195 -> upward crossing
        {8'd133, 1'b0},  // R8 rise of exactly 128
        {8'd5,   1'b0},  // R8 fall of exactly 128
        {8'd255, 1'b1},  // R7 rise by 250
        {8'd0,   1'b1},  // R6 fall by 255 across the boundary
        {8'd100, 1'b0}   // R8 rise by 100
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic f, input logic m);
        logic [7:0] cur;
        @(negedge clk);
        fp = f;
        mk = m;
        cur = f ? 8'd0 : nextpos;
        @(posedge clk);
        nextpos = cur + 8'd1;
        last_cap = cur;
        #1;
    endtask

    task automatic capture(input logic [7:0] p, input logic tog, input string req);
        logic [7:0] held;
        tick(1'b0, 1'b0);
        while (nextpos != p) tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        if (tog) exp_fc = ~exp_fc;
        chk(valid == 1'b1, req, int'(valid), 1);
        chk(phase == p, req, int'(phase), int'(p));
        chk(fcnt == exp_fc, req, int'(fcnt), int'(exp_fc));
        held = phase;
        tick(1'b0, 1'b0);
        chk(valid == 1'b0, "R3 strobe one cycle", int'(valid), 0);
        chk(phase == held && fcnt == exp_fc, "R9 hold", int'(phase), int'(held));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(phase == 8'd0 && fcnt == 1'b0 && valid == 1'b0, "R1 in reset", int'(phase), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(phase == 8'd0 && fcnt == 1'b0 && valid == 1'b0, "R1 after release", int'(valid), 0);

        // R4: marker edges before any frame pulse are ignored
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b1);
            chk(valid == 1'b0, "R4 no strobe", int'(valid), 0);
            tick(1'b0, 1'b0);
            chk(valid == 1'b0 && phase == 8'd0, "R4 phase unchanged", int'(phase), 0);
        end

        // Align
        tick(1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            capture(VEC[v][8:1], VEC[v][0], "R3 R5 R6 R7 R8 vector");
        end

        // R2: pulse in the same cycle as a marker edge captures slot 0
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b1);
        chk(valid == 1'b1 && phase == 8'd0, "R2 pulse-cycle slot", int'(phase), 0);
        chk(fcnt == exp_fc, "R8 step of 100", int'(fcnt), int'(exp_fc));
        tick(1'b0, 1'b0);

        // R2: counter wraps 255 -> 0 with no further pulse
        for (int i = 0; i < 300; i++) tick(1'b0, 1'b0);
        capture(8'd3, 1'b0, "R2 free wrap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule